// File: doc/BRIEF.md
# Strobe-Sampled Cycle Mode Decoder

This block is the control front end of a dual-port video memory controller. It watches an active-low row strobe and an active-low column strobe, both sampled in the system clock domain. On each falling edge it captures the control levels and the shared address bus. From these samples it selects one of twelve operation cycles. It then presents that cycle as a one-hot mode vector, together with the latched row and column addresses, to the write, transfer and refresh engines downstream.

The mode is formed in two stages. A first decode uses five levels captured at the row strobe's falling edge: column strobe, transfer/output enable, write enable, serial enable and the special-function flag. For most cycles that first decode is final. For the two masked/unmasked write families, the choice between plain and block write waits for the special-function flag captured at the first column strobe fall. When the column strobe is already low at the row strobe fall, the cycle is a column-before-row refresh. The row it refreshes comes from an internal 9-bit counter, which steps once per refresh cycle.

All strobe edges are detected against the level seen at the previous clock. Every output changes one clock after the edge that caused it.

Top module: `strobe_mode_decoder`

## Requirements
- R1: Column strobe low at a row strobe fall selects refresh. The refresh mode is bit 0. In that case row_addr_o takes the refresh counter value and all other inputs are ignored. A column fall in the same clock as the row fall counts as low.
- R2: With transfer/output enable low and write enable low at the row fall, the mode bit is chosen as follows. Flag high gives split write transfer, bit 3, whatever serial enable is. Flag low with serial enable low gives write transfer, bit 1. Flag low with serial enable high gives pseudo transfer, bit 2.
- R3: With transfer/output enable low and write enable high, the result is read transfer (bit 4) when the flag is low and split read transfer (bit 5) when the flag is high. Serial enable has no effect.
- R4: With transfer/output enable high and the flag high at the row fall, write enable low gives flash write (bit 8) and write enable high gives colour register access (bit 11). These modes are final at the row fall.
- R5: With transfer/output enable high and the flag low at the row fall, mode_o stays all-zero and mode_vld_o stays low until the first column fall. At that fall the column-edge flag resolves the mode. With write enable low, the result is masked write (bit 6) or masked block write (bit 7). With write enable high, it is read/write (bit 9) or block write (bit 10).
- R6: A row fall latches addr_i (9 bits) into row_addr_o. A column fall inside a non-refresh row cycle latches addr_i[7:0] into col_addr_o and sets col_vld_o. Both take effect one clock after the edge.
- R7: Further column falls in the same row cycle relatch col_addr_o but leave mode_o unchanged, even when the flag differs.
- R8: A row strobe rise clears mode_o, mode_vld_o and col_vld_o on the next clock. A column fall in the same clock as that rise is ignored.
- R9: The refresh counter resets to 0 and steps by one when a refresh cycle's row strobe rises. After 511 it wraps to 0.
- R10: After reset, mode_o, mode_vld_o, row_addr_o, col_addr_o and col_vld_o are all zero.
- R11: Column falls outside a row cycle, or during a refresh cycle, leave col_addr_o and col_vld_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| row_stb_ni | input | 1 | Row strobe, active low |
| col_stb_ni | input | 1 | Column strobe, active low |
| xfer_oe_ni | input | 1 | Transfer / output enable level, active low |
| wr_en_ni | input | 1 | Write enable level, active low |
| ser_en_ni | input | 1 | Serial port enable level, active low |
| sfn_i | input | 1 | Special-function flag |
| addr_i | input | 9 | Multiplexed row / column address |
| mode_o | output | 12 | One-hot operation cycle |
| mode_vld_o | output | 1 | Mode is resolved |
| row_addr_o | output | 9 | Latched row (or refresh row) |
| col_addr_o | output | 8 | Latched column |
| col_vld_o | output | 1 | A column has been latched in this row cycle |

## Verification
Two events can land in the same clock. A column fall can coincide with a row fall, and it can coincide with a row rise. The bench provokes each case by driving both strobes at the same clock edge. A column fall with a row fall must yield a refresh taken from the counter. A column fall with a row rise must be dropped, leaving the previous column address untouched. A behavioural model in the bench tracks the refresh counter through more than 512 refresh cycles, so the wrap is judged against a value the bench computed on its own.

// File: rtl/smd_pkg.sv
package smd_pkg;
  localparam int unsigned NUM_MODES = 12;
  localparam int unsigned MODE_W    = $clog2(NUM_MODES);

  // block-write variants sit one index above their plain counterparts
  typedef enum logic [MODE_W-1:0] {
    MD_CBR_REF,
    MD_WR_XFER,
    MD_PSEUDO_XFER,
    MD_SPLIT_WR_XFER,
    MD_RD_XFER,
    MD_SPLIT_RD_XFER,
    MD_MASK_WR,
    MD_MASK_BLK_WR,
    MD_FLASH_WR,
    MD_RW,
    MD_BLK_WR,
    MD_COLOR_RW
  } mode_e;

  typedef struct packed {
    logic  two_stage;
    mode_e base;
  } first_dec_t;

  function automatic mode_e resolve_mode(mode_e base, logic flag);
    return flag ? mode_e'(MODE_W'(base) + MODE_W'(1)) : base;
  endfunction

  function automatic logic [NUM_MODES-1:0] to_onehot(mode_e m);
    logic [NUM_MODES-1:0] v;
    v    = '0;
    v[m] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/smd_edge_det.sv
module smd_edge_det #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_ni,
  output logic [W-1:0] fall_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= lvl_ni;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign fall_o[i] = prev_q[i] & ~lvl_ni[i];
    assign rise_o[i] = ~prev_q[i] & lvl_ni[i];
  end
endmodule

// File: rtl/smd_row_decode.sv
module smd_row_decode
  import smd_pkg::*;
(
  input  logic       col_ni,
  input  logic       xfer_oe_ni,
  input  logic       wr_en_ni,
  input  logic       ser_en_ni,
  input  logic       sfn_i,
  output first_dec_t dec_o
);
  always_comb begin
    dec_o.two_stage = 1'b0;
    dec_o.base      = MD_CBR_REF;
    if (!col_ni) begin
      dec_o.base = MD_CBR_REF;
    end else if (!xfer_oe_ni) begin
      if (!wr_en_ni) begin
        if (sfn_i)          dec_o.base = MD_SPLIT_WR_XFER;
        else if (ser_en_ni) dec_o.base = MD_PSEUDO_XFER;
        else                dec_o.base = MD_WR_XFER;
      end else begin
        dec_o.base = sfn_i ? MD_SPLIT_RD_XFER : MD_RD_XFER;
      end
    end else if (!wr_en_ni) begin
      dec_o.base      = sfn_i ? MD_FLASH_WR : MD_MASK_WR;
      dec_o.two_stage = ~sfn_i;
    end else begin
      dec_o.base      = sfn_i ? MD_COLOR_RW : MD_RW;
      dec_o.two_stage = ~sfn_i;
    end
  end
endmodule

// File: rtl/smd_refresh_ctr.sv
module smd_refresh_ctr #(
  parameter int unsigned W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;

  // R9
  ref_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> cnt_q == W'($past(cnt_q) + W'(1)));

  // R9
  ref_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_q));
endmodule

// File: rtl/strobe_mode_decoder.sv
module strobe_mode_decoder
  import smd_pkg::*;
#(
  parameter int unsigned ROW_W = 9,
  parameter int unsigned COL_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 row_stb_ni,
  input  logic                 col_stb_ni,
  input  logic                 xfer_oe_ni,
  input  logic                 wr_en_ni,
  input  logic                 ser_en_ni,
  input  logic                 sfn_i,
  input  logic [ROW_W-1:0]     addr_i,
  output logic [NUM_MODES-1:0] mode_o,
  output logic                 mode_vld_o,
  output logic [ROW_W-1:0]     row_addr_o,
  output logic [COL_W-1:0]     col_addr_o,
  output logic                 col_vld_o
);
  localparam int unsigned N_STB = 2;
  localparam int unsigned ROW_IDX = 0;
  localparam int unsigned COL_IDX = 1;

  logic [N_STB-1:0] stb_lvl, stb_fall, stb_rise;
  logic row_fall, row_rise, col_fall;

  assign stb_lvl[ROW_IDX] = row_stb_ni;
  assign stb_lvl[COL_IDX] = col_stb_ni;

  smd_edge_det #(.W(N_STB)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_ni (stb_lvl),
    .fall_o (stb_fall),
    .rise_o (stb_rise)
  );

  assign row_fall = stb_fall[ROW_IDX];
  assign row_rise = stb_rise[ROW_IDX];
  assign col_fall = stb_fall[COL_IDX];

  first_dec_t dec;

  smd_row_decode u_dec (
    .col_ni     (col_stb_ni),
    .xfer_oe_ni (xfer_oe_ni),
    .wr_en_ni   (wr_en_ni),
    .ser_en_ni  (ser_en_ni),
    .sfn_i      (sfn_i),
    .dec_o      (dec)
  );

  logic [ROW_W-1:0] ref_row;
  logic             ref_inc;

  logic                 active_q, is_ref_q, pending_q, vld_q, colv_q;
  mode_e                base_q;
  logic [NUM_MODES-1:0] mode_q;
  logic [ROW_W-1:0]     row_q;
  logic [COL_W-1:0]     col_q;
  logic                 col_take, dec_ref;

  assign ref_inc  = row_rise & active_q & is_ref_q;
  assign col_take = col_fall & active_q & ~is_ref_q & ~row_rise;
  assign dec_ref  = (dec.base == MD_CBR_REF);

  smd_refresh_ctr #(.W(ROW_W)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (ref_inc),
    .cnt_o  (ref_row)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      is_ref_q  <= 1'b0;
      pending_q <= 1'b0;
      vld_q     <= 1'b0;
      colv_q    <= 1'b0;
      base_q    <= MD_CBR_REF;
      mode_q    <= '0;
      row_q     <= '0;
      col_q     <= '0;
    end else if (row_rise) begin
      active_q  <= 1'b0;
      is_ref_q  <= 1'b0;
      pending_q <= 1'b0;
      vld_q     <= 1'b0;
      colv_q    <= 1'b0;
      mode_q    <= '0;
    end else if (row_fall) begin
      active_q  <= 1'b1;
      colv_q    <= 1'b0;
      is_ref_q  <= dec_ref;
      row_q     <= dec_ref ? ref_row : addr_i;
      base_q    <= dec.base;
      pending_q <= dec.two_stage;
      vld_q     <= ~dec.two_stage;
      mode_q    <= dec.two_stage ? '0 : to_onehot(dec.base);
    end else if (col_take) begin
      col_q  <= addr_i[COL_W-1:0];
      colv_q <= 1'b1;
      if (pending_q) begin
        mode_q    <= to_onehot(resolve_mode(base_q, sfn_i));
        vld_q     <= 1'b1;
        pending_q <= 1'b0;
      end
    end
  end

  assign mode_o     = mode_q;
  assign mode_vld_o = vld_q;
  assign row_addr_o = row_q;
  assign col_addr_o = col_q;
  assign col_vld_o  = colv_q;

  // R1
  refresh_row_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_fall && !col_stb_ni) |=> mode_o[MD_CBR_REF] && row_addr_o == $past(ref_row));

  // R5
  one_hot_when_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_vld_o |-> $countones(mode_o) == 1);

  // R5
  quiet_when_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_vld_o |-> mode_o == '0);

  // R7
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_vld_o && !row_rise) |=> mode_vld_o && $stable(mode_o));

  // R8
  clear_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_rise |=> !mode_vld_o && mode_o == '0 && !col_vld_o);

  // R11
  col_only_in_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_vld_o |-> mode_vld_o && !mode_o[MD_CBR_REF]);

  // R11
  col_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_fall && !active_q) |=> $stable(col_addr_o));
endmodule

// File: tb/strobe_mode_decoder_tb_top.sv
module strobe_mode_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic row_n = 1'b1, col_n = 1'b1, xo_n = 1'b1, we_n = 1'b1, se_n = 1'b1, sfn = 1'b0;
  logic [8:0]  addr = '0;
  logic [11:0] mode_o;
  logic        mode_vld_o, col_vld_o;
  logic [8:0]  row_addr_o;
  logic [7:0]  col_addr_o;

  always #2 clk = ~clk;

  strobe_mode_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .row_stb_ni(row_n), .col_stb_ni(col_n),
    .xfer_oe_ni(xo_n), .wr_en_ni(we_n), .ser_en_ni(se_n), .sfn_i(sfn),
    .addr_i(addr), .mode_o(mode_o), .mode_vld_o(mode_vld_o),
    .row_addr_o(row_addr_o), .col_addr_o(col_addr_o), .col_vld_o(col_vld_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_prev_row = 1, m_prev_col = 1, m_active = 0, m_isref = 0, m_pending = 0;
  int m_base = 0, m_mode = -1, m_row = 0, m_col = 0, m_colv = 0, m_ref = 0;

  function automatic string mode_tag(int m);
    case (m)
      0:           return "R1";
      1, 2, 3:     return "R2";
      4, 5:        return "R3";
      8, 11:       return "R4";
      6, 7, 9, 10: return "R5";
      default:     return "R8";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prev_row = 1; m_prev_col = 1; m_active = 0; m_isref = 0; m_pending = 0;
      m_mode = -1; m_row = 0; m_col = 0; m_colv = 0; m_ref = 0;
    end else begin
      int rf, rr, cf;
      rf = (m_prev_row == 1) && (row_n == 1'b0);
      rr = (m_prev_row == 0) && (row_n == 1'b1);
      cf = (m_prev_col == 1) && (col_n == 1'b0);
      if (rr) begin
        if (m_active && m_isref) m_ref = (m_ref + 1) % 512;
        m_active = 0; m_isref = 0; m_pending = 0; m_mode = -1; m_colv = 0;
      end else if (rf) begin
        m_active = 1; m_colv = 0; m_isref = 0; m_pending = 0;
        if (!col_n) begin
          m_isref = 1; m_mode = 0; m_row = m_ref;
        end else begin
          m_row = addr;
          if (!xo_n && !we_n) m_mode = sfn ? 3 : (se_n ? 2 : 1);
          else if (!xo_n)     m_mode = sfn ? 5 : 4;
          else if (sfn)       m_mode = we_n ? 11 : 8;
          else begin
            m_pending = 1; m_mode = -1; m_base = we_n ? 9 : 6;
          end
        end
      end else if (cf && m_active && !m_isref) begin
        m_col = addr[7:0]; m_colv = 1;
        if (m_pending) begin
          m_mode = m_base + (sfn ? 1 : 0); m_pending = 0;
        end
      end
      m_prev_row = row_n; m_prev_col = col_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(mode_tag(m_mode), mode_o, (m_mode < 0) ? 0 : (1 << m_mode));
      chk("R5 vld", mode_vld_o, (m_mode >= 0) ? 1 : 0);
      chk("R6 row", row_addr_o, m_row);
      chk("R6 col", col_addr_o, m_col);
      chk("R11 colv", col_vld_o, m_colv);
    end
  end

  task automatic open_row(input logic xo, input logic we, input logic se, input logic f, input int ra);
    @(negedge clk);
    xo_n = xo; we_n = we; se_n = se; sfn = f; addr = ra[8:0]; row_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic col_hit(input int ca, input logic f);
    @(negedge clk);
    col_n = 1'b0; addr = ca[8:0]; sfn = f;
    @(negedge clk);
    col_n = 1'b1;
  endtask

  task automatic close_row();
    @(negedge clk);
    row_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic refresh_cycle(output int row_seen);
    @(negedge clk);
    col_n = 1'b0;
    @(negedge clk);
    row_n = 1'b0;
    @(negedge clk);
    row_seen = row_addr_o;
    chk("R1 refresh mode", mode_o, 1);
    row_n = 1'b1;
    @(negedge clk);
    col_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int rs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10
    chk("R10 mode", mode_o, 0);
    chk("R10 vld", mode_vld_o, 0);
    chk("R10 row", row_addr_o, 0);
    chk("R10 col", col_addr_o, 0);
    chk("R10 colv", col_vld_o, 0);

    // R2
    open_row(0, 0, 0, 0, 'h155); chk("R2 wr xfer", mode_o, 'h002); chk("R6 row", row_addr_o, 'h155); close_row();
    open_row(0, 0, 1, 0, 'h0AA); chk("R2 pseudo", mode_o, 'h004); close_row();
    open_row(0, 0, 0, 1, 'h001); chk("R2 split wr", mode_o, 'h008); close_row();
    open_row(0, 0, 1, 1, 'h1FF); chk("R2 split wr se high", mode_o, 'h008); close_row();
    // R3
    open_row(0, 1, 0, 0, 'h010); chk("R3 rd xfer", mode_o, 'h010); col_hit('h20, 1); chk("R3 rd xfer after col", mode_o, 'h010); close_row();
    open_row(0, 1, 1, 1, 'h011); chk("R3 split rd", mode_o, 'h020); close_row();
    // R4
    open_row(1, 0, 0, 1, 'h0F0); chk("R4 flash", mode_o, 'h100); chk("R4 vld", mode_vld_o, 1); close_row();
    open_row(1, 1, 1, 1, 'h0F1); chk("R4 color", mode_o, 'h800); close_row();
    // R5 masked family, then R7 second column edge
    open_row(1, 0, 0, 0, 'h123);
    chk("R5 pending mode", mode_o, 0); chk("R5 pending vld", mode_vld_o, 0);
    col_hit('hA5, 1); chk("R5 mask blk", mode_o, 'h080); chk("R6 col", col_addr_o, 'hA5); chk("R6 colv", col_vld_o, 1);
    col_hit('h3C, 0); chk("R7 mode kept", mode_o, 'h080); chk("R7 col relatch", col_addr_o, 'h3C);
    close_row(); chk("R8 cleared mode", mode_o, 0); chk("R8 cleared colv", col_vld_o, 0);
    open_row(1, 0, 1, 0, 'h124); col_hit('h11, 0); chk("R5 mask wr", mode_o, 'h040); close_row();
    open_row(1, 1, 0, 0, 'h125); col_hit('h12, 0); chk("R5 rw", mode_o, 'h200); close_row();
    open_row(1, 1, 0, 0, 'h126); col_hit('h13, 1); chk("R5 blk wr", mode_o, 'h400); close_row();
    // R11 column edge with no row cycle
    col_hit('h77, 0); @(negedge clk); chk("R11 idle col", col_addr_o, 'h13); chk("R11 idle colv", col_vld_o, 0);
    // R8 column fall coincident with row rise
    open_row(1, 1, 0, 1, 'h0C0);
    @(negedge clk); row_n = 1'b1; col_n = 1'b0; addr = 'h066;
    @(negedge clk); chk("R8 col dropped", col_addr_o, 'h13); chk("R8 vld", mode_vld_o, 0);
    col_n = 1'b1;
    // R1 and R9 refresh rows
    refresh_cycle(rs); chk("R9 row0", rs, 0);
    refresh_cycle(rs); chk("R9 row1", rs, 1);
    @(negedge clk); col_n = 1'b0; row_n = 1'b0; addr = 'h1AB;
    @(negedge clk); chk("R1 same-cycle", mode_o, 1); chk("R1 row", row_addr_o, 2);
    col_hit('h55, 0); chk("R11 col in refresh", col_vld_o, 0);
    col_n = 1'b0; row_n = 1'b1;
    @(negedge clk); col_n = 1'b1;
    for (int i = 3; i < 512; i++) refresh_cycle(rs);
    chk("R9 row511", rs, 511);
    refresh_cycle(rs); chk("R9 wrap", rs, 0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule